// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Bit Clock

This block drives one serial peripheral bus as the bus master. A host loads a parallel word, picks a word length and a clock divide value, and pulses `start`. The block pulls the active-low select line down, runs a bit clock that rests low between transfers, sends the word most significant bit first and gathers the returned word at the same time. When the frame is over it raises the select line and gives a one-cycle `done` pulse together with the received word.

The bit clock is built from a base tick. The tick is either every fourth system clock or the rising edge of an external clock, which is first passed through a two-stage synchroniser. A divide value D sets a bit period of D+1 ticks. For an even D the high phase is one tick longer than the low phase. For an odd D the two phases are equal. The select lead time before the first rising edge is one low phase. The data line stops being driven one low phase after the last falling edge, and the select line stays low for one full bit period after that same edge.

The controller is a five-state machine. IDLE waits for `start`. LEAD holds the select low with the clock low. HIGH is the clock-high phase. LOW is the clock-low phase between bits. TAIL is the release window after the last falling edge. The transitions are as follows. IDLE goes to LEAD on start (the frame is accepted). LEAD goes to HIGH at the end of the low phase (first rising edge). HIGH goes to LOW at the end of the high phase when bits remain (falling edge and sample). HIGH goes to TAIL after the last bit's high phase (last falling edge). LOW goes to HIGH at the end of the low phase (next rising edge and shift). TAIL goes to IDLE after one full period (select released, done).

Top module: `spi_serial_master`

## Requirements
- R1: With `src_ext`=0 the base tick occurs at every fourth rising system clock edge counted from reset release, at edges 3, 7, 11 and so on, where edge 0 is the first edge with `rst_n` high. With `src_ext`=1 a tick occurs at the third system edge after a rising edge of `ext_clk`, once the input has passed a two-stage synchroniser.
- R2: With divide value D, the bit period is D+1 ticks. For an even D, `sclk` is high for D/2+1 ticks and low for D/2 ticks. For an odd D, both phases last (D+1)/2 ticks. A D of 0 is treated as 1. `sclk` changes only at a tick edge.
- R3: While idle and in reset, `sclk`=0, `ss_n`=1, `mosi_oe`=0 (so `mosi` is high-impedance), `busy`=0 and `done`=0. `rx_word` resets to 0.
- R4: A `start` seen in IDLE latches `tx_word`, `word_len` and `clk_div`. `ss_n` falls and the first data bit is driven on the next cycle. The first rising `sclk` edge follows one low phase of ticks later.
- R5: Bits go out MSB first, taking bit L-1 of `tx_word` first. `mosi` changes only when `sclk` rises. L is `word_len` limited to the range 8 to 32, and exactly L rising edges occur per frame.
- R6: `miso` is sampled at each falling `sclk` edge. `rx_word` holds the L sampled bits right-justified, with the first sample in bit L-1 and all higher bits at zero.
- R7: `mosi_oe` drops one low phase after the last falling edge. `ss_n` rises one full bit period after the last falling edge.
- R8: `busy` is 1 from the cycle after an accepted `start` until `ss_n` rises. A `start` while busy does not change the frame in progress.
- R9: `done` is a one-cycle pulse in the same cycle that `ss_n` rises. `rx_word` shows the new word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ext | input | 1 | Tick source: 0 = system clock divided by 4, 1 = external clock |
| ext_clk | input | 1 | External tick clock, asynchronous |
| clk_div | input | DIV_W | Bit clock divide value D |
| word_len | input | LEN_W | Bits per frame (limited to 8..DATA_W) |
| start | input | 1 | Frame request strobe |
| tx_word | input | DATA_W | Word to send |
| rx_word | output | DATA_W | Last received word, right-justified |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Bit clock, rests low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out, high-impedance when not driven |
| mosi_oe | output | 1 | Drive enable of `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The bound checker watches several properties on every cycle:
- the clock rests low and the data line is undriven whenever the select line is high;
- the bit clock moves only on a base tick;
- the data bit stays put except at a rising edge or at frame load;
- `busy` covers every selected cycle;
- `done` lasts one cycle and coincides with the select line rising.

The exact phase lengths for even and odd divide values, the lead, release and tri-state times, and the bit order need the bench's tick-level reference model to confirm. The same holds for length clamping, the received word value, the synchronised external source and the rejection of a second `start`.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } spi_state_e;

endpackage

// File: rtl/spi_m_tick_gen.sv
module spi_m_tick_gen #(
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic ext_clk,
    output logic tick
);
    localparam int CW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(INT_DIV - 1);

    logic [CW-1:0]          int_cnt;
    logic [SYNC_STAGES:0]   sync_sh;
    logic                   int_tick;
    logic                   ext_tick;

    // free-running divider for the internal source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_cnt <= '0;
        end else if (int_cnt == LAST) begin
            int_cnt <= '0;
        end else begin
            int_cnt <= int_cnt + 1'b1;
        end
    end

    // synchroniser plus one extra stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_sh <= '0;
        end else begin
            sync_sh <= {sync_sh[SYNC_STAGES-1:0], ext_clk};
        end
    end

    assign int_tick = (int_cnt == LAST);
    assign ext_tick = sync_sh[SYNC_STAGES-1] & ~sync_sh[SYNC_STAGES];
    assign tick     = src_ext ? ext_tick : int_tick;

endmodule

// File: rtl/spi_m_phase_calc.sv
module spi_m_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_raw,
    output logic [DIV_W:0]   hi_ticks,
    output logic [DIV_W:0]   lo_ticks,
    output logic [DIV_W:0]   per_ticks
);
    logic [DIV_W:0] div_eff;

    always_comb begin
        div_eff   = (div_raw == '0) ? (DIV_W+1)'(1) : {1'b0, div_raw};
        per_ticks = div_eff + 1'b1;
        // low phase is the rounded-down half of the period; high takes the rest
        lo_ticks  = per_ticks >> 1;
        hi_ticks  = per_ticks - lo_ticks;
    end

endmodule

// File: rtl/spi_m_shifter.sv
module spi_m_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              shift_tx,
    input  logic              sample_rx,
    input  logic              capture,
    input  logic              miso,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_hold
);
    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [SH_W-1:0]   shamt;

    assign shamt  = SH_W'(DATA_W) - SH_W'(load_len);
    assign tx_bit = tx_sr[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word << shamt;
        end else if (shift_tx) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (load) begin
            rx_sr <= '0;
        end else if (sample_rx) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold <= '0;
        end else if (capture) begin
            rx_hold <= rx_sr;
        end
    end

endmodule

// File: rtl/spi_m_ctrl.sv
module spi_m_ctrl
    import spi_m_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = 6,
    parameter int MIN_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] len_raw,
    input  logic [DIV_W:0]   hi_in,
    input  logic [DIV_W:0]   lo_in,
    input  logic [DIV_W:0]   per_in,
    output logic [LEN_W-1:0] len_eff,
    output logic             load,
    output logic             shift_tx,
    output logic             sample_rx,
    output logic             capture,
    output logic             sclk,
    output logic             ss_n,
    output logic             oe,
    output logic             busy,
    output logic             done
);
    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);

    spi_state_e      state, state_nx;
    logic [DIV_W:0]  cnt;
    logic [DIV_W:0]  hi_q, lo_q, per_q;
    logic [DIV_W:0]  target;
    logic [LEN_W-1:0] bits_left;
    logic            phase_end;
    logic            done_q;

    always_comb begin
        if (len_raw < LEN_LO) begin
            len_eff = LEN_LO;
        end else if (len_raw > LEN_HI) begin
            len_eff = LEN_HI;
        end else begin
            len_eff = len_raw;
        end
    end

    always_comb begin
        unique case (state)
            ST_HIGH: target = hi_q;
            ST_TAIL: target = per_q;
            default: target = lo_q;
        endcase
        phase_end = tick && (cnt == target - 1'b1);
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_LEAD;
            ST_LEAD: if (phase_end) state_nx = ST_HIGH;
            ST_HIGH: if (phase_end) state_nx = (bits_left == LEN_W'(1)) ? ST_TAIL : ST_LOW;
            ST_LOW:  if (phase_end) state_nx = ST_HIGH;
            ST_TAIL: if (phase_end) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // state register with its phase and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            per_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state == ST_TAIL) && phase_end;
            if (state_nx != state) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (state == ST_IDLE && start) begin
                bits_left <= len_eff;
                hi_q      <= hi_in;
                lo_q      <= lo_in;
                per_q     <= per_in;
            end else if (state == ST_HIGH && phase_end) begin
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    // outputs and strobes
    always_comb begin
        load      = 1'b0;
        shift_tx  = 1'b0;
        sample_rx = 1'b0;
        capture   = 1'b0;
        sclk      = 1'b0;
        ss_n      = 1'b0;
        oe        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ss_n = 1'b1;
                load = start;
            end
            ST_LEAD: begin
                oe = 1'b1;
            end
            ST_HIGH: begin
                sclk      = 1'b1;
                oe        = 1'b1;
                sample_rx = phase_end;
            end
            ST_LOW: begin
                oe       = 1'b1;
                shift_tx = phase_end;
            end
            ST_TAIL: begin
                oe      = (cnt < lo_q);
                capture = phase_end;
            end
            default: ss_n = 1'b1;
        endcase
        busy = (state != ST_IDLE);
        done = done_q;
    end

endmodule

// File: rtl/spi_serial_master.sv
module spi_serial_master #(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = $clog2(DATA_W) + 1,
    parameter int MIN_LEN = 8,
    parameter int INT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ext,
    input  logic              ext_clk,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              ss_n,
    output wire               mosi,
    output logic              mosi_oe,
    input  logic              miso
);
    logic             tick_w;
    logic [DIV_W:0]   hi_w, lo_w, per_w;
    logic [LEN_W-1:0] len_w;
    logic             load_w, shift_w, sample_w, capture_w;
    logic             tx_bit_w;

    spi_m_tick_gen #(
        .INT_DIV     (INT_DIV),
        .SYNC_STAGES (2)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_ext (src_ext),
        .ext_clk (ext_clk),
        .tick    (tick_w)
    );

    spi_m_phase_calc #(
        .DIV_W (DIV_W)
    ) u_phase (
        .div_raw   (clk_div),
        .hi_ticks  (hi_w),
        .lo_ticks  (lo_w),
        .per_ticks (per_w)
    );

    spi_m_ctrl #(
        .DATA_W  (DATA_W),
        .DIV_W   (DIV_W),
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .start     (start),
        .len_raw   (word_len),
        .hi_in     (hi_w),
        .lo_in     (lo_w),
        .per_in    (per_w),
        .len_eff   (len_w),
        .load      (load_w),
        .shift_tx  (shift_w),
        .sample_rx (sample_w),
        .capture   (capture_w),
        .sclk      (sclk),
        .ss_n      (ss_n),
        .oe        (mosi_oe),
        .busy      (busy),
        .done      (done)
    );

    spi_m_shifter #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .load_word (tx_word),
        .load_len  (len_w),
        .shift_tx  (shift_w),
        .sample_rx (sample_w),
        .capture   (capture_w),
        .miso      (miso),
        .tx_bit    (tx_bit_w),
        .rx_hold   (rx_word)
    );

    assign mosi = mosi_oe ? tx_bit_w : 1'bz;

endmodule

// File: rtl/spi_m_checker.sv
module spi_m_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic sclk,
    input logic ss_n,
    input logic mosi_oe,
    input logic mosi_d,
    input logic busy,
    input logic done
);
    // R3: deselected bus rests with clock low and data undriven
    p_idle_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (!sclk && !mosi_oe));

    // R2: the bit clock only moves on a base tick
    p_clk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R5: within a frame the data bit changes only with a rising clock
    p_data_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$past(ss_n) && !$rose(sclk)) |-> $stable(mosi_d));

    // R8: busy covers every selected cycle
    p_busy_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |-> busy);

    // R9: done is a single cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done coincides with release of the select line
    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(ss_n) && !busy));

endmodule

bind spi_serial_master spi_m_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .sclk    (sclk),
    .ss_n    (ss_n),
    .mosi_oe (mosi_oe),
    .mosi_d  (tx_bit_w),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_spi_serial_master.sv
`timescale 1ns/1ps
module sim_spi_serial_master;
    localparam int DW = 32;
    localparam int VW = 8;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_ext = 1'b0;
    logic          ext_clk = 1'b0;
    logic [VW-1:0] clk_div = '0;
    logic [LW-1:0] word_len = '0;
    logic          start = 1'b0;
    logic [DW-1:0] tx_word = '0;
    logic [DW-1:0] rx_word;
    logic          busy, done, sclk, ss_n, mosi_oe;
    wire           mosi;
    logic          miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_serial_master u0 (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .ext_clk(ext_clk),
        .clk_div(clk_div), .word_len(word_len), .start(start),
        .tx_word(tx_word), .rx_word(rx_word), .busy(busy), .done(done),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        bit sc;
        bit oe;
        bit dat;
        bit hi_seg;
        int n;
    } seg_t;

    seg_t          segq[$];
    int            rem;
    int            ext_q[$];
    int            edge_k = 0;
    logic [DW-1:0] m_rx = '0;
    logic [DW-1:0] m_rx_out = '0;
    bit            m_done = 0;
    bit            model_on = 0;

    function automatic int clamp_len(input int l);
        if (l < 8) return 8;
        if (l > 32) return 32;
        return l;
    endfunction

    task automatic build_frame();
        int d;
        int lo;
        int hi;
        int L;
        seg_t s;
        d  = (clk_div == 0) ? 1 : int'(clk_div);
        lo = (d + 1) / 2;
        hi = d + 1 - lo;
        L  = clamp_len(int'(word_len));
        m_rx = '0;
        s = '{sc:0, oe:1, dat:tx_word[L-1], hi_seg:0, n:lo};
        segq.push_back(s);
        for (int i = 0; i < L; i++) begin
            s = '{sc:1, oe:1, dat:tx_word[L-1-i], hi_seg:1, n:hi};
            segq.push_back(s);
            s = '{sc:0, oe:1, dat:tx_word[L-1-i], hi_seg:0, n:lo};
            segq.push_back(s);
        end
        s = '{sc:0, oe:0, dat:0, hi_seg:0, n:hi};
        segq.push_back(s);
        rem = segq[0].n;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_k = 0;
            segq.delete();
            m_done = 0;
        end else begin
            bit t;
            bit t_ext;
            while (ext_q.size() > 0 && ext_q[0] < edge_k) void'(ext_q.pop_front());
            t_ext = (ext_q.size() > 0 && ext_q[0] == edge_k);
            t = src_ext ? t_ext : ((edge_k % 4) == 3);
            m_done = 0;
            if (segq.size() > 0) begin
                if (t) begin
                    rem--;
                    if (rem == 0) begin
                        if (segq[0].hi_seg) m_rx = {m_rx[DW-2:0], miso};
                        void'(segq.pop_front());
                        if (segq.size() == 0) begin
                            m_done = 1;
                            m_rx_out = m_rx;
                        end else begin
                            rem = segq[0].n;
                        end
                    end
                end
            end else if (start) begin
                build_frame();
            end
            edge_k++;
        end
    end

    // ---------------- slave, ext clock, per-cycle compare ----------------
    logic [DW-1:0] slave_word = '0;
    int            slave_len = 8;
    int            sk = 0;
    int            rises = 0;
    logic [DW-1:0] mosi_rec = '0;
    bit            prev_sclk = 0;
    bit            ext_run = 0;
    int            ext_ph = 0;

    always @(negedge clk) begin
        if (ext_run) begin
            ext_ph++;
            if (ext_ph == 3) begin
                ext_ph = 0;
                ext_clk = ~ext_clk;
                if (ext_clk) ext_q.push_back(edge_k + 2);
            end
        end
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                rises++;
                if (sk < slave_len) miso = slave_word[slave_len-1-sk];
                sk++;
            end
            if (!sclk && prev_sclk) mosi_rec = {mosi_rec[DW-2:0], mosi};
            prev_sclk = sclk;
        end
        if (model_on) begin
            bit e_sc, e_ss, e_oe, e_dat, e_busy;
            if (segq.size() > 0) begin
                e_sc = segq[0].sc; e_ss = 0; e_oe = segq[0].oe;
                e_dat = segq[0].dat; e_busy = 1;
            end else begin
                e_sc = 0; e_ss = 1; e_oe = 0; e_dat = 0; e_busy = 0;
            end
            chk(sclk == e_sc, src_ext ? "R1 sclk (ext tick)" : "R2 sclk phase", DW'(sclk), DW'(e_sc));
            chk(ss_n == e_ss, "R4 ss_n timing", DW'(ss_n), DW'(e_ss));
            chk(mosi_oe == e_oe, "R7 mosi_oe timing", DW'(mosi_oe), DW'(e_oe));
            if (e_oe) chk(mosi == e_dat, "R5 mosi bit", DW'(mosi), DW'(e_dat));
            chk(busy == e_busy, "R8 busy", DW'(busy), DW'(e_busy));
            chk(done == m_done, "R9 done", DW'(done), DW'(m_done));
            if (m_done) chk(rx_word == m_rx_out, "R6 rx_word at done", rx_word, m_rx_out);
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_frame(input bit ext, input int div, input int len,
                             input logic [DW-1:0] tx, input logic [DW-1:0] sw, input int dup_at);
        int L;
        logic [DW-1:0] mask;
        L = clamp_len(len);
        mask = (L == 32) ? '1 : ((DW'(1) << L) - 1);
        @(negedge clk);
        src_ext = ext; clk_div = VW'(div); word_len = LW'(len); tx_word = tx;
        slave_word = sw; slave_len = L; sk = 0; rises = 0; mosi_rec = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tx_word = ~tx;
        if (dup_at > 0) begin
            repeat (dup_at) @(negedge clk);
            clk_div = VW'(div + 3); word_len = LW'(9);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R8 busy holds after ignored start", DW'(busy), 1);
        end
        while (!done) @(negedge clk);
        chk(rises == L, "R5 rising edge count", DW'(rises), DW'(L));
        chk((mosi_rec & mask) == (tx & mask), "R5 transmitted word MSB first", mosi_rec & mask, tx & mask);
        chk(rx_word == (sw & mask), "R6 received word", rx_word, sw & mask);
        repeat (6) @(negedge clk);
        chk(ss_n && !sclk && !mosi_oe && !busy, "R3 idle after frame",
            DW'({ss_n, sclk, mosi_oe, busy}), DW'(4'b1000));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 0, "R3 reset sclk", DW'(sclk), 0);
        chk(ss_n == 1, "R3 reset ss_n", DW'(ss_n), 1);
        chk(mosi_oe == 0, "R3 reset mosi_oe", DW'(mosi_oe), 0);
        chk(busy == 0 && done == 0, "R3 reset busy/done", DW'({busy, done}), 0);
        chk(rx_word == 0, "R3 reset rx_word", rx_word, 0);
        rst_n = 1'b1;
        model_on = 1;
        repeat (5) @(negedge clk);
        run_frame(0, 1, 8,  32'h0000_00A5, 32'h0000_003C, 0);   // R2 odd D=1
        run_frame(0, 4, 12, 32'h0000_0B6D, 32'h0000_0927, 0);   // R2 even D=4
        run_frame(0, 3, 40, 32'hC3A5_5A1E, 32'h8BAD_F00D, 0);   // R2 odd D=3, R5 clamp high
        run_frame(0, 0, 5,  32'h0000_0081, 32'h0000_00FE, 0);   // R2 D=0, R5 clamp low
        run_frame(0, 2, 16, 32'h0000_F00F, 32'h0000_1234, 40);  // R8 ignored start
        ext_run = 1;
        repeat (20) @(negedge clk);
        run_frame(1, 2, 16, 32'h0000_A1B2, 32'h0000_5C6D, 0);   // R1 external source
        run_frame(1, 5, 10, 32'h0000_02D3, 32'h0000_0155, 0);   // R1 with odd D
        ext_run = 0;
        repeat (10) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule